// File: doc/BRIEF.md
# Keyboard Controller Command Engine

This block is the host-side register and command engine of a PC-style keyboard controller. The host reaches it through two byte-wide ports that share one write strobe. A select bit chooses between them: the data port (select 0) and the command port (select 1). Command bytes are decoded against a fixed code set. Some commands change the mode byte or the output-port byte at once. Some produce a reply byte. Some arm a pending target, and the next data-port write then goes to that target.

The engine keeps three bytes. The mode byte holds the interrupt enables and the keyboard and aux disable bits. The status byte is read by the host. The output-port byte drives the A20 gate and, through its bit 0, a system-reset request. The serial device side, the device byte queues and the output-buffer arbitration live outside this block. The engine reaches them through one-cycle byte strobes:
- bytes sent to the keyboard,
- bytes sent to the aux device,
- controller reply bytes,
- a re-evaluation request for the output buffer.

The external arbiter reports back two live flags: output buffer full and aux output full.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After synchronous reset the mode byte is 0x03, the status byte is 0x18 (with both buffer-full inputs low), the output-port view is 0xCF, A20 is high, no pending target is armed and every strobe output is low.
- R2: The engine emits exactly one reply strobe with aux flag 0 for each reply command:
  - 0x20 replies with the current mode byte.
  - 0xAA replies with 0x55 and sets status bit 2, which stays set until reset.
  - 0xA9 and 0xAB reply with 0x00.
  - 0xC0 replies with 0x80.
  - 0xD0 replies with the output-port view.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm a target. The next data write goes to that target and no further:
  - 0x60 sends it to the mode byte.
  - 0xD1 sends it to the output port.
  - 0xD2 sends it out as a reply with aux flag 0.
  - 0xD3 sends it out as a reply with aux flag 1.
  - 0xD4 sends it to the aux device.

  After that data write the target is disarmed.
- R4: A command byte whose upper nibble is 0xF is folded before decode. With bit 0 clear it behaves as 0xFE, which pulses the reset request for one cycle. With bit 0 set it behaves as 0xFF, which has no effect.
- R5: The mode disable bits are set and cleared by commands:
  - 0xA7 sets mode bit 5 (aux disable) and 0xA8 clears it.
  - 0xAD sets mode bit 4 (keyboard disable) and 0xAE clears it.

  Each clearing command, each mode-byte write and each data write to a device also pulses the re-evaluation strobe.
- R6: Command 0xDD clears output-port bit 1 and drives A20 low. Command 0xDF sets bit 1 and drives A20 high.
- R7: A data write to the output port stores bits 7:6 and 3:0 and drives A20 from bit 1. It pulses the reset request when bit 0 is 0. In the output-port view, bits 5 and 4 always mirror the aux-full and buffer-full inputs.
- R8: A data write with no armed target pulses the keyboard strobe with the byte and clears mode bit 4. A data write after 0xD4 pulses the aux strobe with the byte and clears mode bit 5.
- R9: The status byte is laid out as follows:
  - bit 0 mirrors buffer-full,
  - bit 5 mirrors aux-full,
  - bit 2 is self-test done,
  - bit 3 is 1 after a command write and 0 after a data write,
  - bit 4 is constantly 1,
  - bits 1, 6 and 7 are 0.
- R10: An unrecognised command code pulses the error strobe for one cycle. It leaves the mode byte, the output port, the armed target and status bit 2 unchanged.
- R11: Every effect of a write appears on the outputs in the clock cycle after the edge that samples the write strobe. Strobe outputs last exactly one cycle unless another write causes them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_sel | input | 1 | Port select: 0 data, 1 command |
| host_wdata | input | 8 | Host write byte |
| ob_full_i | input | 1 | Output buffer full, from the arbiter |
| ob_aux_full_i | input | 1 | Output buffer holds aux data, from the arbiter |
| status_o | output | 8 | Status byte seen by the host |
| mode_o | output | 8 | Mode byte |
| outport_o | output | 8 | Output-port view |
| a20_o | output | 1 | A20 gate level |
| sysrst_req_o | output | 1 | One-cycle system reset request |
| cmd_err_o | output | 1 | One-cycle unrecognised-command flag |
| ob_recheck_o | output | 1 | One-cycle output-buffer re-evaluation request |
| kbd_wr_o | output | 1 | Byte strobe toward the keyboard |
| kbd_wdata_o | output | 8 | Byte toward the keyboard |
| aux_wr_o | output | 1 | Byte strobe toward the aux device |
| aux_wdata_o | output | 8 | Byte toward the aux device |
| reply_wr_o | output | 1 | Controller reply strobe |
| reply_data_o | output | 8 | Controller reply byte |
| reply_aux_o | output | 1 | Reply is tagged as aux data |

## Verification
Every registered result of a write falls due one cycle after the strobe is sampled. This covers the mode byte, the stored output-port bits, the status bits, A20 and all strobes. The live buffer-full bits in the status and output-port views follow their inputs with no delay. The bench raises each write at a falling edge, lowers it at the next falling edge, and compares every output there, halfway through the cycle in which the result must be present. An extra idle cycle then shows that the one-cycle strobes have dropped.

// File: rtl/kbc_pkg.sv
// Package: shared codes, bit positions and decoded-operation types for the
// keyboard controller command engine. Assumes byte-wide host accesses.
package kbc_pkg;

    localparam int BYTE_W = 8;

    // Command codes understood by the decoder
    localparam logic [BYTE_W-1:0] CMD_RD_MODE    = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_WR_MODE    = 8'h60;
    localparam logic [BYTE_W-1:0] CMD_AUX_OFF    = 8'hA7;
    localparam logic [BYTE_W-1:0] CMD_AUX_ON     = 8'hA8;
    localparam logic [BYTE_W-1:0] CMD_AUX_TEST   = 8'hA9;
    localparam logic [BYTE_W-1:0] CMD_SELF_TEST  = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_KBD_TEST   = 8'hAB;
    localparam logic [BYTE_W-1:0] CMD_KBD_OFF    = 8'hAD;
    localparam logic [BYTE_W-1:0] CMD_KBD_ON     = 8'hAE;
    localparam logic [BYTE_W-1:0] CMD_RD_INPUT   = 8'hC0;
    localparam logic [BYTE_W-1:0] CMD_RD_OUTPORT = 8'hD0;
    localparam logic [BYTE_W-1:0] CMD_WR_OUTPORT = 8'hD1;
    localparam logic [BYTE_W-1:0] CMD_WR_KBD_REP = 8'hD2;
    localparam logic [BYTE_W-1:0] CMD_WR_AUX_REP = 8'hD3;
    localparam logic [BYTE_W-1:0] CMD_WR_AUX_DEV = 8'hD4;
    localparam logic [BYTE_W-1:0] CMD_A20_LOW    = 8'hDD;
    localparam logic [BYTE_W-1:0] CMD_A20_HIGH   = 8'hDF;
    localparam logic [BYTE_W-1:0] CMD_RESET      = 8'hFE;
    localparam logic [BYTE_W-1:0] CMD_NOP        = 8'hFF;

    // Reset values and bit positions
    localparam logic [BYTE_W-1:0] MODE_RST   = 8'h03;
    localparam logic [BYTE_W-1:0] OUTP_RST   = 8'hCF;
    localparam int MODE_KBD_OFF_BIT = 4;
    localparam int MODE_AUX_OFF_BIT = 5;
    localparam int OUTP_RUN_BIT     = 0;
    localparam int OUTP_A20_BIT     = 1;

    typedef enum logic [3:0] {
        OP_BAD, OP_NOP, OP_RD_MODE, OP_RD_OUTPORT, OP_RD_CONST, OP_SELFTEST,
        OP_ARM, OP_AUX_OFF, OP_AUX_ON, OP_KBD_OFF, OP_KBD_ON,
        OP_A20_LOW, OP_A20_HIGH, OP_RESET
    } op_e;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_MODE, TGT_OUTPORT, TGT_KBD_REP, TGT_AUX_REP, TGT_AUX_DEV
    } tgt_e;

endpackage

// File: rtl/kbc_cmd_decode.sv
// Module: combinational command decoder. Folds pulse-class codes (upper
// nibble all ones) into reset or no-op, then maps the code to an operation,
// an arm target and a constant reply byte. Assumes a stable input byte.
module kbc_cmd_decode
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SELFTEST_REPLY = 8'h55,
    parameter logic [BYTE_W-1:0] INPUT_PORT_VAL = 8'h80
) (
    input  logic [BYTE_W-1:0] cmd_byte,
    output op_e               dec_op,
    output tgt_e              dec_tgt,
    output logic [BYTE_W-1:0] dec_const
);
    localparam int NIB = BYTE_W / 2;

    logic [BYTE_W-1:0] folded;

    // Fold pulse-class commands: bit 0 clear means reset, set means no-op
    always_comb begin
        if (cmd_byte[BYTE_W-1:NIB] == {NIB{1'b1}})
            folded = cmd_byte[0] ? CMD_NOP : CMD_RESET;
        else
            folded = cmd_byte;
    end

    // Map the folded code onto an operation class
    always_comb begin
        dec_op    = OP_BAD;
        dec_tgt   = TGT_NONE;
        dec_const = '0;
        case (folded)
            CMD_RD_MODE:    dec_op = OP_RD_MODE;
            CMD_RD_OUTPORT: dec_op = OP_RD_OUTPORT;
            CMD_AUX_TEST,
            CMD_KBD_TEST:   dec_op = OP_RD_CONST;
            CMD_RD_INPUT:   begin dec_op = OP_RD_CONST; dec_const = INPUT_PORT_VAL; end
            CMD_SELF_TEST:  begin dec_op = OP_SELFTEST; dec_const = SELFTEST_REPLY; end
            CMD_WR_MODE:    begin dec_op = OP_ARM; dec_tgt = TGT_MODE;    end
            CMD_WR_OUTPORT: begin dec_op = OP_ARM; dec_tgt = TGT_OUTPORT; end
            CMD_WR_KBD_REP: begin dec_op = OP_ARM; dec_tgt = TGT_KBD_REP; end
            CMD_WR_AUX_REP: begin dec_op = OP_ARM; dec_tgt = TGT_AUX_REP; end
            CMD_WR_AUX_DEV: begin dec_op = OP_ARM; dec_tgt = TGT_AUX_DEV; end
            CMD_AUX_OFF:    dec_op = OP_AUX_OFF;
            CMD_AUX_ON:     dec_op = OP_AUX_ON;
            CMD_KBD_OFF:    dec_op = OP_KBD_OFF;
            CMD_KBD_ON:     dec_op = OP_KBD_ON;
            CMD_A20_LOW:    dec_op = OP_A20_LOW;
            CMD_A20_HIGH:   dec_op = OP_A20_HIGH;
            CMD_RESET:      dec_op = OP_RESET;
            CMD_NOP:        dec_op = OP_NOP;
            default:        dec_op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/kbc_reg_file.sv
// Module: holds the mode byte, the stored output-port bits, the self-test and
// last-write-was-command status bits and the armed data-write target.
// Assumes command and data writes are never requested in the same cycle.
module kbc_reg_file
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  op_e               dec_op,
    input  tgt_e              dec_tgt,
    output tgt_e              pend_q,
    output logic [BYTE_W-1:0] mode_q,
    output logic [1:0]        outp_hi_q,
    output logic [3:0]        outp_lo_q,
    output logic              selftest_q,
    output logic              cmd_last_q
);
    // Register updates for command and data writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_RST;
            outp_hi_q  <= OUTP_RST[7:6];
            outp_lo_q  <= OUTP_RST[3:0];
            pend_q     <= TGT_NONE;
            selftest_q <= 1'b0;
            cmd_last_q <= 1'b1;
        end else if (cmd_wr) begin
            cmd_last_q <= 1'b1;
            case (dec_op)
                OP_SELFTEST: selftest_q <= 1'b1;
                OP_ARM:      pend_q <= dec_tgt;
                OP_AUX_OFF:  mode_q[MODE_AUX_OFF_BIT] <= 1'b1;
                OP_AUX_ON:   mode_q[MODE_AUX_OFF_BIT] <= 1'b0;
                OP_KBD_OFF:  mode_q[MODE_KBD_OFF_BIT] <= 1'b1;
                OP_KBD_ON:   mode_q[MODE_KBD_OFF_BIT] <= 1'b0;
                OP_A20_LOW:  outp_lo_q[OUTP_A20_BIT] <= 1'b0;
                OP_A20_HIGH: outp_lo_q[OUTP_A20_BIT] <= 1'b1;
                default: ;
            endcase
        end else if (data_wr) begin
            cmd_last_q <= 1'b0;
            pend_q     <= TGT_NONE;
            case (pend_q)
                TGT_NONE:    mode_q[MODE_KBD_OFF_BIT] <= 1'b0;
                TGT_MODE:    mode_q <= wdata;
                TGT_OUTPORT: begin
                    outp_hi_q <= wdata[7:6];
                    outp_lo_q <= wdata[3:0];
                end
                TGT_AUX_DEV: mode_q[MODE_AUX_OFF_BIT] <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/kbc_event_gen.sv
// Module: produces the registered one-cycle strobes (device bytes, replies,
// reset request, error, re-evaluation) for each host write. Data bytes
// hold their last value between strobes.
module kbc_event_gen
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  op_e               dec_op,
    input  logic [BYTE_W-1:0] dec_const,
    input  tgt_e              pend_q,
    input  logic [BYTE_W-1:0] mode_q,
    input  logic [BYTE_W-1:0] outp_view,
    output logic              kbd_wr_o,
    output logic [BYTE_W-1:0] kbd_wdata_o,
    output logic              aux_wr_o,
    output logic [BYTE_W-1:0] aux_wdata_o,
    output logic              reply_wr_o,
    output logic [BYTE_W-1:0] reply_data_o,
    output logic              reply_aux_o,
    output logic              sysrst_req_o,
    output logic              cmd_err_o,
    output logic              ob_recheck_o
);
    // Strobe generation: every pulse defaults low and is raised for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kbd_wr_o     <= 1'b0;
            kbd_wdata_o  <= '0;
            aux_wr_o     <= 1'b0;
            aux_wdata_o  <= '0;
            reply_wr_o   <= 1'b0;
            reply_data_o <= '0;
            reply_aux_o  <= 1'b0;
            sysrst_req_o <= 1'b0;
            cmd_err_o    <= 1'b0;
            ob_recheck_o <= 1'b0;
        end else begin
            kbd_wr_o     <= 1'b0;
            aux_wr_o     <= 1'b0;
            reply_wr_o   <= 1'b0;
            sysrst_req_o <= 1'b0;
            cmd_err_o    <= 1'b0;
            ob_recheck_o <= 1'b0;
            if (cmd_wr) begin
                case (dec_op)
                    OP_RD_MODE: begin
                        reply_wr_o <= 1'b1; reply_data_o <= mode_q; reply_aux_o <= 1'b0;
                    end
                    OP_RD_OUTPORT: begin
                        reply_wr_o <= 1'b1; reply_data_o <= outp_view; reply_aux_o <= 1'b0;
                    end
                    OP_RD_CONST, OP_SELFTEST: begin
                        reply_wr_o <= 1'b1; reply_data_o <= dec_const; reply_aux_o <= 1'b0;
                    end
                    OP_KBD_ON, OP_AUX_ON: ob_recheck_o <= 1'b1;
                    OP_RESET:             sysrst_req_o <= 1'b1;
                    OP_BAD:               cmd_err_o <= 1'b1;
                    default: ;
                endcase
            end else if (data_wr) begin
                case (pend_q)
                    TGT_NONE: begin
                        kbd_wr_o <= 1'b1; kbd_wdata_o <= wdata; ob_recheck_o <= 1'b1;
                    end
                    TGT_MODE:    ob_recheck_o <= 1'b1;
                    TGT_OUTPORT: sysrst_req_o <= ~wdata[OUTP_RUN_BIT];
                    TGT_KBD_REP: begin
                        reply_wr_o <= 1'b1; reply_data_o <= wdata; reply_aux_o <= 1'b0;
                    end
                    TGT_AUX_REP: begin
                        reply_wr_o <= 1'b1; reply_data_o <= wdata; reply_aux_o <= 1'b1;
                    end
                    TGT_AUX_DEV: begin
                        aux_wr_o <= 1'b1; aux_wdata_o <= wdata; ob_recheck_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/kbc_cmd_engine.sv
// Module: top of the keyboard controller command engine. Splits host writes
// into command and data writes, and composes the status byte and the
// output-port view from stored bits and the live buffer-full inputs.
// Assumes single-cycle write strobes and an external output-buffer arbiter.
module kbc_cmd_engine
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SELFTEST_REPLY = 8'h55,
    parameter logic [BYTE_W-1:0] INPUT_PORT_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              ob_full_i,
    input  logic              ob_aux_full_i,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] mode_o,
    output logic [BYTE_W-1:0] outport_o,
    output logic              a20_o,
    output logic              sysrst_req_o,
    output logic              cmd_err_o,
    output logic              ob_recheck_o,
    output logic              kbd_wr_o,
    output logic [BYTE_W-1:0] kbd_wdata_o,
    output logic              aux_wr_o,
    output logic [BYTE_W-1:0] aux_wdata_o,
    output logic              reply_wr_o,
    output logic [BYTE_W-1:0] reply_data_o,
    output logic              reply_aux_o
);
    logic              cmd_wr, data_wr;
    op_e               dec_op;
    tgt_e              dec_tgt, pend_q;
    logic [BYTE_W-1:0] dec_const, mode_q, outp_view;
    logic [1:0]        outp_hi_q;
    logic [3:0]        outp_lo_q;
    logic              selftest_q, cmd_last_q;

    // Split the shared write strobe by port select
    always_comb begin
        cmd_wr  = host_wr & host_sel;
        data_wr = host_wr & ~host_sel;
    end

    // Compose host-visible bytes from stored bits and live inputs
    always_comb begin
        outp_view = {outp_hi_q, ob_aux_full_i, ob_full_i, outp_lo_q};
        status_o  = {2'b00, ob_aux_full_i, 1'b1, cmd_last_q, selftest_q, 1'b0, ob_full_i};
        mode_o    = mode_q;
        outport_o = outp_view;
        a20_o     = outp_lo_q[OUTP_A20_BIT];
    end

    kbc_cmd_decode #(
        .SELFTEST_REPLY (SELFTEST_REPLY),
        .INPUT_PORT_VAL (INPUT_PORT_VAL)
    ) u_decode (
        .cmd_byte  (host_wdata),
        .dec_op    (dec_op),
        .dec_tgt   (dec_tgt),
        .dec_const (dec_const)
    );

    kbc_reg_file u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .data_wr    (data_wr),
        .wdata      (host_wdata),
        .dec_op     (dec_op),
        .dec_tgt    (dec_tgt),
        .pend_q     (pend_q),
        .mode_q     (mode_q),
        .outp_hi_q  (outp_hi_q),
        .outp_lo_q  (outp_lo_q),
        .selftest_q (selftest_q),
        .cmd_last_q (cmd_last_q)
    );

    kbc_event_gen u_events (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .data_wr      (data_wr),
        .wdata        (host_wdata),
        .dec_op       (dec_op),
        .dec_const    (dec_const),
        .pend_q       (pend_q),
        .mode_q       (mode_q),
        .outp_view    (outp_view),
        .kbd_wr_o     (kbd_wr_o),
        .kbd_wdata_o  (kbd_wdata_o),
        .aux_wr_o     (aux_wr_o),
        .aux_wdata_o  (aux_wdata_o),
        .reply_wr_o   (reply_wr_o),
        .reply_data_o (reply_data_o),
        .reply_aux_o  (reply_aux_o),
        .sysrst_req_o (sysrst_req_o),
        .cmd_err_o    (cmd_err_o),
        .ob_recheck_o (ob_recheck_o)
    );
endmodule

// File: rtl/kbc_cmd_engine_chk.sv
// Module: property checker for the command engine, attached by bind.
// Assumes it sees the top-level ports only.
module kbc_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_sel,
    input logic [7:0] host_wdata,
    input logic [7:0] status_o,
    input logic [7:0] mode_o,
    input logic       a20_o,
    input logic       sysrst_req_o,
    input logic       cmd_err_o,
    input logic       kbd_wr_o,
    input logic       aux_wr_o,
    input logic       reply_wr_o
);
    AST_UNLOCKED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[4] && status_o[1] == 1'b0 && status_o[7:6] == 2'b00); // R9
    AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2] |=> status_o[2]); // R2
    AST_A20_HIGH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata == 8'hDF) |=> a20_o); // R6
    AST_A20_LOW_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata == 8'hDD) |=> !a20_o); // R6
    AST_FOLD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata[7:4] == 4'hF && !host_wdata[0]) |=> sysrst_req_o); // R4
    AST_FOLD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata[7:4] == 4'hF && host_wdata[0]) |=> !sysrst_req_o && !cmd_err_o); // R4
    AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |-> $stable(mode_o) && $stable(a20_o)); // R10
    AST_KBD_BYTE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_wr_o |-> !mode_o[4]); // R8
    AST_AUX_BYTE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        aux_wr_o |-> !mode_o[5]); // R8
    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kbd_wr_o, aux_wr_o, reply_wr_o})); // R3
    AST_STROBE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr) |=> !kbd_wr_o && !aux_wr_o && !reply_wr_o && !cmd_err_o); // R11
endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (.*);

// File: tb/kbc_cmd_engine_tb.sv
module kbc_cmd_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_sel = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       ob_full_i = 1'b0, ob_aux_full_i = 1'b0;
    logic [7:0] status_o, mode_o, outport_o, kbd_wdata_o, aux_wdata_o, reply_data_o;
    logic       a20_o, sysrst_req_o, cmd_err_o, ob_recheck_o;
    logic       kbd_wr_o, aux_wr_o, reply_wr_o, reply_aux_o;

    always #4 clk = ~clk;

    kbc_cmd_engine u_dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_mode, m_out;
    bit m_st2, m_st3;
    int m_pend;
    // Expected strobes of the current step
    bit e_kbd, e_aux, e_rep, e_rep_aux, e_rst, e_err, e_chkp;
    logic [7:0] e_kbd_d, e_aux_d, e_rep_d;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_view();
        return {m_out[7:6], ob_aux_full_i, ob_full_i, m_out[3:0]};
    endfunction

    function automatic logic [7:0] exp_status();
        return {2'b00, ob_aux_full_i, 1'b1, m_st3, m_st2, 1'b0, ob_full_i};
    endfunction

    task automatic model_reset();
        m_mode = 8'h03; m_out = 8'hCF; m_st2 = 0; m_st3 = 1; m_pend = 0;
    endtask

    task automatic model(input bit sel, input logic [7:0] d);
        logic [7:0] c;
        e_kbd = 0; e_aux = 0; e_rep = 0; e_rep_aux = 0; e_rst = 0; e_err = 0; e_chkp = 0;
        if (sel) begin
            m_st3 = 1;
            c = d;
            if (c[7:4] == 4'hF) c = c[0] ? 8'hFF : 8'hFE;
            case (c)
                8'h20: begin e_rep = 1; e_rep_d = m_mode; end
                8'hAA: begin e_rep = 1; e_rep_d = 8'h55; m_st2 = 1; end
                8'hA9, 8'hAB: begin e_rep = 1; e_rep_d = 8'h00; end
                8'hC0: begin e_rep = 1; e_rep_d = 8'h80; end
                8'hD0: begin e_rep = 1; e_rep_d = exp_view(); end
                8'h60: m_pend = 1;
                8'hD1: m_pend = 2;
                8'hD2: m_pend = 3;
                8'hD3: m_pend = 4;
                8'hD4: m_pend = 5;
                8'hA7: m_mode[5] = 1'b1;
                8'hA8: begin m_mode[5] = 1'b0; e_chkp = 1; end
                8'hAD: m_mode[4] = 1'b1;
                8'hAE: begin m_mode[4] = 1'b0; e_chkp = 1; end
                8'hDD: m_out[1] = 1'b0;
                8'hDF: m_out[1] = 1'b1;
                8'hFE: e_rst = 1;
                8'hFF: ;
                default: e_err = 1;
            endcase
        end else begin
            m_st3 = 0;
            case (m_pend)
                0: begin e_kbd = 1; e_kbd_d = d; m_mode[4] = 1'b0; e_chkp = 1; end
                1: begin m_mode = d; e_chkp = 1; end
                2: begin m_out = d; e_rst = ~d[0]; end
                3: begin e_rep = 1; e_rep_d = d; e_rep_aux = 0; end
                4: begin e_rep = 1; e_rep_d = d; e_rep_aux = 1; end
                default: begin e_aux = 1; e_aux_d = d; m_mode[5] = 1'b0; e_chkp = 1; end
            endcase
            m_pend = 0;
        end
    endtask

    task automatic check_all();
        chk("R5 mode", mode_o, m_mode);
        chk("R9 status", status_o, exp_status());
        chk("R7 outport", outport_o, exp_view());
        chk("R6 a20", a20_o, m_out[1]);
        chk("R8 kbd strobe", kbd_wr_o, e_kbd);
        if (e_kbd) chk("R8 kbd byte", kbd_wdata_o, e_kbd_d);
        chk("R8 aux strobe", aux_wr_o, e_aux);
        if (e_aux) chk("R8 aux byte", aux_wdata_o, e_aux_d);
        chk("R2 reply strobe", reply_wr_o, e_rep);
        if (e_rep) chk("R2 reply byte", {reply_aux_o, reply_data_o}, {e_rep_aux, e_rep_d});
        chk("R4 reset req", sysrst_req_o, e_rst);
        chk("R10 err", cmd_err_o, e_err);
        chk("R5 recheck", ob_recheck_o, e_chkp);
    endtask

    // One host write, checked one cycle later at the falling edge (R11)
    task automatic step(input bit sel, input logic [7:0] d);
        model(sel, d);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        check_all();
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R11 kbd pulse gone", kbd_wr_o, 0);
        chk("R11 aux pulse gone", aux_wr_o, 0);
        chk("R11 reply pulse gone", reply_wr_o, 0);
        chk("R11 misc pulses gone", {sysrst_req_o, cmd_err_o, ob_recheck_o}, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    localparam int NPOOL = 28;
    function automatic logic [7:0] pick_cmd(input int i);
        logic [7:0] pool [NPOOL] = '{8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB,
            8'hAD, 8'hAE, 8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF,
            8'hF0, 8'hF7, 8'hFE, 8'hFF, 8'hF3, 8'h00, 8'h33, 8'hB5, 8'h61, 8'hD5, 8'hE0};
        return pool[i];
    endfunction

    initial begin
        void'($urandom(32'h0C0FFEE5));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode_o, 8'h03);
        chk("R1 status", status_o, 8'h18);
        chk("R1 outport", outport_o, 8'hCF);
        chk("R1 a20", a20_o, 1);
        chk("R1 strobes", {kbd_wr_o, aux_wr_o, reply_wr_o, sysrst_req_o, cmd_err_o, ob_recheck_o}, 0);

        // R2 reply commands
        step(1, 8'h20); chk("R2 mode reply", reply_data_o, 8'h03);
        step(1, 8'hAA); chk("R2 self-test bit", status_o[2], 1);
        step(1, 8'hA9); step(1, 8'hAB); step(1, 8'hC0); step(1, 8'hD0);
        idle_check();

        // R3 arm then route; target clears after one data byte
        step(1, 8'h60); chk("R3 arm has no strobe", {kbd_wr_o, reply_wr_o}, 0);
        step(0, 8'h57); chk("R3 mode written", mode_o, 8'h57);
        step(0, 8'h12); chk("R3 target cleared, byte to keyboard", kbd_wr_o, 1);
        chk("R8 keyboard disable cleared", mode_o[4], 0);
        step(1, 8'hD2); step(0, 8'hA5); chk("R3 kbd reply", {reply_wr_o, reply_aux_o, reply_data_o}, {2'b10, 8'hA5});
        step(1, 8'hD3); step(0, 8'h3C); chk("R3 aux reply", {reply_wr_o, reply_aux_o, reply_data_o}, {2'b11, 8'h3C});
        step(1, 8'hA7); chk("R5 aux disable set", mode_o[5], 1);
        step(1, 8'hD4); step(0, 8'h99); chk("R8 aux byte", {aux_wr_o, aux_wdata_o}, {1'b1, 8'h99});
        chk("R8 aux disable cleared", mode_o[5], 0);

        // R4 folding
        step(1, 8'hF0); chk("R4 F0 resets", sysrst_req_o, 1);
        step(1, 8'hF5); chk("R4 F5 no-op", {sysrst_req_o, cmd_err_o}, 0);
        step(1, 8'hFE); step(1, 8'hFF);

        // R5 disable bits
        step(1, 8'hAD); chk("R5 kbd disable set", mode_o[4], 1);
        step(1, 8'hAE); chk("R5 kbd enable recheck", ob_recheck_o, 1);
        step(1, 8'hA8);

        // R6 A20 commands
        step(1, 8'hDD); chk("R6 a20 low", a20_o, 0);
        step(1, 8'hDF); chk("R6 a20 high", a20_o, 1);

        // R7 output port writes
        step(1, 8'hD1); step(0, 8'hFD); chk("R7 a20 from bit1", {a20_o, sysrst_req_o}, 2'b00);
        step(1, 8'hD1); step(0, 8'h02); chk("R7 reset on bit0 low", {a20_o, sysrst_req_o}, 2'b11);
        step(1, 8'hD1); step(0, 8'hCF);

        // R9 status with live buffer flags
        ob_full_i = 1'b1; ob_aux_full_i = 1'b1;
        step(1, 8'hD0); chk("R9 status flags", status_o, 8'h3D);
        chk("R7 outport mirrors flags", reply_data_o, 8'hFF);
        ob_full_i = 1'b0; ob_aux_full_i = 1'b0;

        // R10 unrecognised codes
        step(1, 8'h60);
        step(1, 8'h33); chk("R10 error pulse", cmd_err_o, 1);
        step(0, 8'h0B); chk("R10 armed target kept", mode_o, 8'h0B);
        step(1, 8'hB5);
        idle_check();

        // Random mix
        for (int i = 0; i < 600; i++) begin
            ob_full_i = 1'($urandom_range(0, 1));
            ob_aux_full_i = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0)
                step(0, 8'($urandom_range(0, 255)));
            else
                step(1, pick_cmd($urandom_range(0, NPOOL - 1)));
            if ($urandom_range(0, 7) == 0) begin
                idle_check();
                chk("R9 idle status", status_o, exp_status());
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule